// File: doc/BRIEF.md
# Bus Slave Window Decoder

This block sits between an external bus interface and on-board memory. It watches every incoming bus cycle and decides whether the cycle falls into one of two slave windows. One window decodes the low 24 address bits and the other decodes all 32 bits. On a hit it produces the byte offset into local memory. It also checks the access against a protection boundary at the bottom of the window. If the access is refused, it raises an error pulse and keeps the access away from memory.

Software programs the block through a small write-only register port. This port sets:
- the two window base addresses,
- a shared window size, given as a power of two,
- the protection boundary,
- a global slave enable,
- an enable for the 24-bit window,
- the protection policy.

A combinational ready flag reports whether the current programming is legal. The decode result is registered, so it appears one clock after the bus cycle is presented.

Top module: `slave_win_dec`

## Requirements
- R1: A cycle with `busSpace` = 2'b10 (32-bit class) hits when the global enable is set, `baseReady` is high, and base ≤ `busAddr` < base + 2^size. In that case `localOffset` = `busAddr` − base, and `memEn` is high unless the access is denied.
- R2: A cycle with `busSpace` = 2'b01 (24-bit class) decodes only `busAddr[23:0]` against the 24-bit base, using the same size and offset rule. Bits 31:24 of the address are ignored.
- R3: With the global enable clear, neither window hits. With only the 24-bit enable clear, the 24-bit window never hits and the 32-bit window still responds.
- R4: A write that hits at an offset below the protection boundary is denied. The block drives `accessErr` high and `memEn` low, and `winHit` stays high. A boundary of 0 protects nothing.
- R5: With the protection-mode bit set, reads below the boundary are denied too. With it clear, such reads reach memory without error.
- R6: A cycle with `busSpace` = 2'b00 or 2'b11 gives no hit, no memory enable and no error, whatever its address.
- R7: `baseReady` is high only when three conditions hold: the 24-bit base is a multiple of 2^MEM_AW, the 32-bit base is a multiple of the window size, and the size exponent lies in [MIN_LOG, MEM_AW]. While `baseReady` is low, neither window hits.
- R8: The register write port uses these selects:
  - 0: 32-bit base.
  - 1: 24-bit base.
  - 2: size exponent.
  - 3: protection boundary.
  - 4: control. Bit 0 is the global enable, bit 1 the 24-bit enable and bit 2 the protection mode.

  Reset values: both bases 0, size MEM_AW, boundary 0, control 0. A write affects bus cycles sampled from the next clock edge on. A cycle sampled in the same edge as the write uses the old setting.
- R9: All bus outputs are registered one cycle after `busValid` is sampled. With `busValid` low they are all zero, so `accessErr` is a single-cycle pulse per denied cycle.
- R10: Take a 4 MiB 32-bit window at 0x0800_0000 with a 0x2_0000 boundary. It hits for 0x0800_0000..0x083F_FFFF. Writes to 0x0800_0000..0x0801_FFFF are denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 3 | Register select |
| regWrData | input | 32 | Register write data |
| busValid | input | 1 | Bus cycle present |
| busSpace | input | 2 | Address-space class of the cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 32 | Bus address |
| winHit | output | 1 | Cycle decoded into a window |
| memEn | output | 1 | Access forwarded to local memory |
| localOffset | output | MEM_AW | Byte offset into local memory |
| accessErr | output | 1 | Denied access pulse |
| baseReady | output | 1 | Window programming is valid |

## Verification
A register write and a bus decode can land on the same clock edge. The decode must then use the configuration from before the write. The bench provokes this by dropping the global enable in the very cycle that carries a write access. It expects a hit with the memory enable set on that cycle, and a miss on the next access.

Protection and window matching also meet in the boundary cycles. Sweeps over each configuration place addresses exactly one byte either side of the base, the boundary and the window end. Each result is compared with arithmetic expectations.

// File: rtl/swd_pkg.sv
package swd_pkg;
  typedef enum logic [1:0] {
    SPC_NONE = 2'b00,
    SPC_A24  = 2'b01,
    SPC_A32  = 2'b10,
    SPC_RSVD = 2'b11
  } space_e;

  typedef enum logic [2:0] {
    REG_A32_BASE   = 3'd0,
    REG_A24_BASE   = 3'd1,
    REG_WIN_LOG2   = 3'd2,
    REG_PROT_BOUND = 3'd3,
    REG_CTRL       = 3'd4
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic a32On;
    logic a24On;
    logic denyReads;
  } winStrb_t;

  localparam int NUM_WIN = 2;
endpackage

// File: rtl/swd_ctrl.sv
module swd_ctrl
  import swd_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int A24_W   = 24,
  parameter int MEM_AW  = 22,
  parameter int MIN_LOG = 12,
  parameter int LOG_W   = $clog2(ADDR_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic [2:0]        regSel,
  input  logic [31:0]       regWrData,
  output winStrb_t          strb,
  output logic [ADDR_W-1:0] a32Base,
  output logic [A24_W-1:0]  a24Base,
  output logic [LOG_W-1:0]  winLog2,
  output logic [MEM_AW-1:0] protBound,
  output logic              baseReady
);
  logic slvEnQ, a24EnQ, protRdWrQ;
  logic [ADDR_W-1:0] sizeMask;
  logic a32Aligned, a24Aligned, logInRange;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a32Base   <= '0;
      a24Base   <= '0;
      winLog2   <= LOG_W'(MEM_AW);
      protBound <= '0;
      slvEnQ    <= 1'b0;
      a24EnQ    <= 1'b0;
      protRdWrQ <= 1'b0;
    end else if (regWrEn) begin
      case (regSel_e'(regSel))
        REG_A32_BASE:   a32Base   <= regWrData[ADDR_W-1:0];
        REG_A24_BASE:   a24Base   <= regWrData[A24_W-1:0];
        REG_WIN_LOG2:   winLog2   <= regWrData[LOG_W-1:0];
        REG_PROT_BOUND: protBound <= regWrData[MEM_AW-1:0];
        REG_CTRL: begin
          slvEnQ    <= regWrData[0];
          a24EnQ    <= regWrData[1];
          protRdWrQ <= regWrData[2];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    sizeMask   = (ADDR_W'(1) << winLog2) - ADDR_W'(1);
    a32Aligned = (a32Base & sizeMask) == '0;
    a24Aligned = a24Base[MEM_AW-1:0] == '0;
    logInRange = (winLog2 >= LOG_W'(MIN_LOG)) && (winLog2 <= LOG_W'(MEM_AW));
    baseReady  = a32Aligned && a24Aligned && logInRange;
    strb.a32On     = slvEnQ && baseReady;
    strb.a24On     = slvEnQ && a24EnQ && baseReady;
    strb.denyReads = protRdWrQ;
  end
endmodule

// File: rtl/swd_window_match.sv
module swd_window_match #(
  parameter int ADDR_W = 32,
  parameter int MEM_AW = 22,
  parameter int LOG_W  = $clog2(ADDR_W)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic [LOG_W-1:0]  sizeLog2,
  input  logic              enable,
  output logic              hit,
  output logic [MEM_AW-1:0] offset
);
  logic [ADDR_W-1:0] diff;

  always_comb begin
    diff   = addr - base;
    hit    = enable && ((diff >> sizeLog2) == '0);
    offset = diff[MEM_AW-1:0];
  end
endmodule

// File: rtl/swd_datapath.sv
module swd_datapath
  import swd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int A24_W  = 24,
  parameter int MEM_AW = 22,
  parameter int LOG_W  = $clog2(ADDR_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busValid,
  input  logic [1:0]        busSpace,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  winStrb_t          strb,
  input  logic [ADDR_W-1:0] a32Base,
  input  logic [A24_W-1:0]  a24Base,
  input  logic [LOG_W-1:0]  winLog2,
  input  logic [MEM_AW-1:0] protBound,
  output logic              winHit,
  output logic              memEn,
  output logic [MEM_AW-1:0] localOffset,
  output logic              accessErr
);
  logic [ADDR_W-1:0] winAddr  [NUM_WIN];
  logic [ADDR_W-1:0] winBase  [NUM_WIN];
  logic              winOn    [NUM_WIN];
  space_e            winSpace [NUM_WIN];
  logic              winMatch [NUM_WIN];
  logic [MEM_AW-1:0] winOff   [NUM_WIN];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    if (w == 0) begin : g_a24
      assign winAddr[w]  = {{(ADDR_W-A24_W){1'b0}}, busAddr[A24_W-1:0]};
      assign winBase[w]  = {{(ADDR_W-A24_W){1'b0}}, a24Base};
      assign winOn[w]    = strb.a24On;
      assign winSpace[w] = SPC_A24;
    end else begin : g_a32
      assign winAddr[w]  = busAddr;
      assign winBase[w]  = a32Base;
      assign winOn[w]    = strb.a32On;
      assign winSpace[w] = SPC_A32;
    end
    swd_window_match #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW), .LOG_W(LOG_W)) u_match (
      .addr(winAddr[w]), .base(winBase[w]), .sizeLog2(winLog2),
      .enable(winOn[w]), .hit(winMatch[w]), .offset(winOff[w])
    );
  end

  logic              hitNow, denyNow;
  logic [MEM_AW-1:0] offNow;

  always_comb begin
    hitNow = 1'b0;
    offNow = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (busValid && (space_e'(busSpace) == winSpace[w]) && winMatch[w]) begin
        hitNow = 1'b1;
        offNow = winOff[w];
      end
    end
    denyNow = hitNow && (offNow < protBound) && (busWrite || strb.denyReads);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      winHit      <= 1'b0;
      memEn       <= 1'b0;
      localOffset <= '0;
      accessErr   <= 1'b0;
    end else begin
      winHit      <= hitNow;
      memEn       <= hitNow && !denyNow;
      localOffset <= offNow;
      accessErr   <= denyNow;
    end
  end
endmodule

// File: rtl/slave_win_dec.sv
module slave_win_dec
  import swd_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int A24_W   = 24,
  parameter int MEM_AW  = 22,
  parameter int MIN_LOG = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic [2:0]        regSel,
  input  logic [31:0]       regWrData,
  input  logic              busValid,
  input  logic [1:0]        busSpace,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output logic              winHit,
  output logic              memEn,
  output logic [MEM_AW-1:0] localOffset,
  output logic              accessErr,
  output logic              baseReady
);
  localparam int LOG_W = $clog2(ADDR_W);

  winStrb_t          strb;
  logic [ADDR_W-1:0] a32Base;
  logic [A24_W-1:0]  a24Base;
  logic [LOG_W-1:0]  winLog2;
  logic [MEM_AW-1:0] protBound;

  swd_ctrl #(.ADDR_W(ADDR_W), .A24_W(A24_W), .MEM_AW(MEM_AW),
             .MIN_LOG(MIN_LOG), .LOG_W(LOG_W)) u_ctrl (
    .clk, .rst_n, .regWrEn, .regSel, .regWrData,
    .strb, .a32Base, .a24Base, .winLog2, .protBound, .baseReady
  );

  swd_datapath #(.ADDR_W(ADDR_W), .A24_W(A24_W), .MEM_AW(MEM_AW),
                 .LOG_W(LOG_W)) u_dp (
    .clk, .rst_n, .busValid, .busSpace, .busWrite, .busAddr,
    .strb, .a32Base, .a24Base, .winLog2, .protBound,
    .winHit, .memEn, .localOffset, .accessErr
  );
endmodule

// File: rtl/slave_win_dec_chk.sv
module slave_win_dec_chk
  import swd_pkg::*;
#(
  parameter int MEM_AW = 22
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busValid,
  input logic [1:0]        busSpace,
  input logic              busWrite,
  input logic              winHit,
  input logic              memEn,
  input logic [MEM_AW-1:0] localOffset,
  input logic              accessErr,
  input logic              baseReady,
  input winStrb_t          strb
);
  p_deny_no_mem_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accessErr |-> (winHit && !memEn));

  p_mem_needs_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    memEn |-> winHit);

  p_other_space_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busSpace == SPC_NONE || busSpace == SPC_RSVD) |-> (!winHit && !accessErr && !memEn));

  p_a32_disabled_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busSpace == SPC_A32 && !strb.a32On) |-> !winHit);

  p_a24_disabled_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busSpace == SPC_A24 && !strb.a24On) |-> !winHit);

  p_read_allowed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busValid && !busWrite && !strb.denyReads) |-> !accessErr);

  p_not_ready_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!baseReady) |-> !winHit);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!busValid) |-> (!winHit && !memEn && !accessErr && localOffset == '0));
endmodule

bind slave_win_dec slave_win_dec_chk #(.MEM_AW(MEM_AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .busValid(busValid), .busSpace(busSpace),
  .busWrite(busWrite), .winHit(winHit), .memEn(memEn),
  .localOffset(localOffset), .accessErr(accessErr),
  .baseReady(baseReady), .strb(strb)
);

// File: tb/slave_win_dec_tb.sv
`timescale 1ns/1ps
module slave_win_dec_tb_top;
  localparam int ADDR_W  = 32;
  localparam int MEM_AW  = 22;
  localparam int MIN_LOG = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic regWrEn = 1'b0;
  logic [2:0] regSel = '0;
  logic [31:0] regWrData = '0;
  logic busValid = 1'b0;
  logic [1:0] busSpace = '0;
  logic busWrite = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic winHit, memEn, accessErr, baseReady;
  logic [MEM_AW-1:0] localOffset;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // shadow configuration
  longint mA32 = 0, mA24 = 0, mLog = MEM_AW, mBound = 0;
  bit mSlv = 0, mA24En = 0, mProt = 0;

  always #2.5 clk = ~clk;

  slave_win_dec #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW), .MIN_LOG(MIN_LOG)) dut_i (
    .clk, .rst_n, .regWrEn, .regSel, .regWrData, .busValid, .busSpace,
    .busWrite, .busAddr, .winHit, .memEn, .localOffset, .accessErr, .baseReady
  );

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic bit modelReady();
    longint sz = longint'(1) << mLog;
    return (mA24 % (longint'(1) << MEM_AW) == 0) && (mA32 % sz == 0) &&
           (mLog >= MIN_LOG) && (mLog <= MEM_AW);
  endfunction

  task automatic regWrite(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic configure(input longint a32, input longint a24, input longint lg,
                           input longint bnd, input bit slv, input bit a24e, input bit prot);
    mA32 = a32; mA24 = a24; mLog = lg; mBound = bnd;
    mSlv = slv; mA24En = a24e; mProt = prot;
    regWrite(3'd0, 32'(a32));
    regWrite(3'd1, 32'(a24));
    regWrite(3'd2, 32'(lg));
    regWrite(3'd3, 32'(bnd));
    regWrite(3'd4, {29'd0, prot, a24e, slv});
    chk("R7", "baseReady", longint'(baseReady), longint'(modelReady()));
  endtask

  task automatic access(input longint addr, input logic [1:0] sp, input bit wr, input bit ex10);
    longint a, b, sz, diff;
    bit en, hit, deny, inWin;
    string tag;
    sz = longint'(1) << mLog;
    if (sp == 2'b01) begin
      a = addr & 64'hFF_FFFF; b = mA24; en = mSlv && mA24En;
    end else begin
      a = addr & 64'hFFFF_FFFF; b = mA32; en = mSlv;
    end
    inWin = (a >= b) && (a - b < sz);
    diff  = a - b;
    hit   = (sp == 2'b01 || sp == 2'b10) && modelReady() && en && inWin;
    deny  = hit && (diff < mBound) && (wr || mProt);
    if (sp == 2'b00 || sp == 2'b11) tag = "R6";
    else if (!modelReady()) tag = "R7";
    else if (!en) tag = "R3";
    else if (hit && diff < mBound && !wr) tag = "R5";
    else if (deny) tag = "R4";
    else if (sp == 2'b01) tag = "R2";
    else tag = "R1";
    if (ex10 && sp == 2'b10) tag = {tag, "/R10"};

    @(negedge clk);
    busValid = 1'b1; busAddr = 32'(addr); busSpace = sp; busWrite = wr;
    @(negedge clk);
    busValid = 1'b0;
    chk(tag, "winHit", longint'(winHit), longint'(hit));
    chk(tag, "memEn", longint'(memEn), longint'(hit && !deny));
    chk(tag, "accessErr", longint'(accessErr), longint'(deny));
    if (hit) chk(tag, "localOffset", longint'(localOffset), diff & ((longint'(1) << MEM_AW) - 1));
    @(negedge clk);
    chk("R9", "idle outputs", longint'({winHit, memEn, accessErr, |localOffset}), 0);
  endtask

  task automatic sweep(input bit ex10);
    longint sz = longint'(1) << mLog;
    longint pts [12];
    pts[0]  = mA32 - 1;  pts[1]  = mA32;          pts[2]  = mA32 + mBound - 1;
    pts[3]  = mA32 + mBound; pts[4] = mA32 + sz - 1; pts[5] = mA32 + sz;
    pts[6]  = mA24 - 1;  pts[7]  = mA24 | 64'hA500_0000; pts[8] = mA24 + mBound - 1;
    pts[9]  = (mA24 + mBound) | 64'h5A00_0000; pts[10] = mA24 + sz - 1; pts[11] = mA24 + sz;
    for (int i = 0; i < 12; i++)
      for (int sp = 0; sp < 4; sp++)
        for (int wr = 0; wr < 2; wr++)
          access(pts[i] & 64'hFFFF_FFFF, 2'(sp), bit'(wr), ex10);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state (R8, R9)
    chk("R8", "baseReady after reset", longint'(baseReady), 1);
    chk("R9", "outputs after reset", longint'({winHit, memEn, accessErr, |localOffset}), 0);
    access(64'h0000_0100, 2'b10, 1'b1, 1'b0);   // global enable off at reset: R3

    // example configuration (R10)
    configure(64'h0800_0000, 64'h40_0000, 22, 64'h2_0000, 1, 1, 0);
    sweep(1'b1);
    configure(64'h0800_0000, 64'h40_0000, 22, 64'h2_0000, 1, 1, 1);
    sweep(1'b0);
    configure(64'h0800_0000, 64'h40_0000, 22, 64'h2_0000, 1, 0, 1);
    sweep(1'b0);
    configure(64'h0800_0000, 64'h40_0000, 22, 64'h2_0000, 0, 1, 1);
    sweep(1'b0);
    configure(64'h0800_0000, 64'h10_0000, 22, 64'h2_0000, 1, 1, 0);   // misaligned 24-bit base
    sweep(1'b0);
    configure(64'h1234_0000, 64'h80_0000, 16, 64'h100, 1, 1, 1);
    sweep(1'b0);
    configure(64'h1234_8000, 64'h80_0000, 16, 64'h100, 1, 1, 0);      // misaligned 32-bit base
    sweep(1'b0);
    configure(64'h1234_0000, 64'h80_0000, 11, 64'h100, 1, 1, 0);      // size below minimum
    sweep(1'b0);
    configure(64'h0800_0000, 64'h40_0000, 22, 64'h0, 1, 1, 1);        // zero boundary
    access(64'h0800_0000, 2'b10, 1'b1, 1'b0);
    access(64'h0040_0000, 2'b01, 1'b0, 1'b0);

    // R8: register write and decode on the same edge
    configure(64'h0800_0000, 64'h40_0000, 22, 64'h2_0000, 1, 1, 0);
    @(negedge clk);
    regWrEn = 1'b1; regSel = 3'd4; regWrData = 32'd0;
    busValid = 1'b1; busSpace = 2'b10; busWrite = 1'b1; busAddr = 32'h0810_0000;
    @(negedge clk);
    regWrEn = 1'b0; busValid = 1'b0;
    chk("R8", "same-edge hit uses old enable", longint'(winHit), 1);
    chk("R8", "same-edge memEn uses old enable", longint'(memEn), 1);
    mSlv = 0; mA24En = 0; mProt = 0;
    access(64'h0810_0000, 2'b10, 1'b1, 1'b0);
    chk("R8", "miss after enable cleared", longint'(winHit), 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule